// File: doc/BRIEF.md
# Flash bus write-cycle guard

This block sits between an asynchronous parallel memory bus and an internal command engine, and runs on a fast system clock. It passes the active-low chip-enable, output-enable and write-enable lines through a two-flop synchronizer, together with the address and data buses. It then decides whether a write strobe is genuine. A strobe counts only if three things hold. The bus must be in a legal write state: chip-enable low, write-enable low and output-enable high. That state must last for a minimum number of clock samples, so that short noise pulses are rejected. The power-up blackout period must also be over. Each accepted strobe produces one single-cycle write event for the command engine, with the latched address and data.

The strobe qualifier is a four-state machine:
- `ST_VOID`: blocked; waits for write-enable high with supply good.
- `ST_IDLE`: waiting for a write state to begin.
- `ST_QUAL`: counting consecutive legal samples.
- `ST_ARMED`: minimum width met; waiting for write-enable to rise.

Its transitions are:
- Reset, or supply loss from any state, goes to `ST_VOID`.
- `ST_VOID` goes to `ST_IDLE` once write-enable is seen high with supply good.
- `ST_IDLE` goes to `ST_QUAL` when a write state begins after the blackout. It goes to `ST_VOID` when a write state begins during the blackout.
- `ST_QUAL` goes to `ST_ARMED` after `MIN_LOW` legal samples. It goes to `ST_VOID` if the write state breaks early.
- `ST_ARMED` goes to `ST_IDLE` on a clean rise of write-enable, which fires the event. It goes to `ST_VOID` on any other exit from the write state.

The `hold_read` output tells the command engine to stay in read mode. It is high for the whole blackout period and whenever the digital supply-good input is low. The glitch width (`MIN_LOW`) and the blackout length (`BLACKOUT`) are parameters counted in clock cycles.

Top module: `flash_write_guard`

## Requirements
- R1: While `rst_n` is low, `wr_evt` is 0 and `hold_read` is 1.
- R2: `hold_read` is 1 from reset until `BLACKOUT` rising clock edges have occurred with `rst_n` high. It is also 1 in any cycle where `supply_ok` is 0. It is 0 otherwise.
- R3: No write event comes from a write state that was present at reset release and held through the blackout. No write event comes from a strobe that began during the blackout.
- R4: A legal strobe lasting at least `MIN_LOW` samples, whose write-enable then rises while chip-enable is low and output-enable is high, produces exactly one event. `wr_evt` is high for one cycle, after the third rising clock edge that samples `bus_we_n` high.
- R5: `wr_addr` takes the address sampled on the first cycle of the write state. `wr_data` takes the data sampled on the cycle where write-enable is seen high. Both hold their values while `wr_evt` is 0.
- R6: A write state lasting fewer than `MIN_LOW` clock samples gives no event. One lasting exactly `MIN_LOW` samples gives an event.
- R7: If output-enable goes low or chip-enable goes high during a strobe, the strobe gives no event. This includes chip-enable rising in the same sample as write-enable.
- R8: A sample with `supply_ok` low abandons any strobe in progress. No new strobe is accepted until write-enable has been seen high with `supply_ok` high.
- R9: A write state that begins with chip-enable falling while write-enable is already low is qualified like one led by write-enable. Its address is taken at the chip-enable fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low power-up reset, asynchronous assert |
| supply_ok | input | 1 | digital supply-good indication, synchronous |
| bus_ce_n | input | 1 | bus chip-enable, active low, asynchronous |
| bus_oe_n | input | 1 | bus output-enable, active low, asynchronous |
| bus_we_n | input | 1 | bus write-enable, active low, asynchronous |
| bus_addr | input | ADDR_W | bus address |
| bus_data | input | DATA_W | bus write data |
| wr_evt | output | 1 | one-cycle qualified write event |
| wr_addr | output | ADDR_W | address of the last write event |
| wr_data | output | DATA_W | data of the last write event |
| hold_read | output | 1 | keep the command engine in read mode |

## Verification
The main function is tried with several kinds of strobe:
- Strobes led by write-enable, at several widths and with varied address and data. Widths just below, at and above `MIN_LOW` separate the glitch filter from an off-by-one counter.
- Strobes led by chip-enable, which show the write state is taken as a whole rather than from one line.
- Strobes broken by an output-enable dip, an early chip-enable rise, or chip-enable rising together with write-enable. Each of these hits a different exit from `ST_QUAL` or `ST_ARMED`.

The address bus is changed after the strobe starts and the data bus is changed before the rise. This separates the correct capture points from capture at the wrong edge.

Two patterns target the blackout. In one, the write state is held from reset. In the other, a strobe starts inside the blackout. Supply drops are applied both during a strobe and while the bus is idle.

// File: rtl/fwg_pkg.sv
package fwg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_QUAL,
        ST_ARMED,
        ST_VOID
    } wg_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
    } wg_ctrl_t;

endpackage

// File: rtl/wg_sync.sv
module wg_sync #(
    parameter int               WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic meta_q;
        logic stab_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[b];
                stab_q <= RST_VAL[b];
            end else begin
                meta_q <= d_in[b];
                stab_q <= meta_q;
            end
        end

        assign d_out[b] = stab_q;
    end

endmodule

// File: rtl/wg_blackout.sv
module wg_blackout #(
    parameter int BLACKOUT = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready
);

    if (BLACKOUT == 0) begin : g_none
        assign ready = 1'b1;
    end else begin : g_count
        localparam int CW = $clog2(BLACKOUT + 1);
        localparam logic [CW-1:0] LIMIT = CW'(BLACKOUT);

        logic [CW-1:0] cnt_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (cnt_q != LIMIT) begin
                cnt_q <= cnt_q + CW'(1);
            end
        end

        assign ready = (cnt_q == LIMIT);
    end

endmodule

// File: rtl/wg_strobe_fsm.sv
module wg_strobe_fsm
    import fwg_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int DATA_W  = 8,
    parameter int MIN_LOW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              ready,
    input  wg_ctrl_t          ctrl,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [DATA_W-1:0] s_data,
    output logic              wr_evt,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    localparam int CNT_W = $clog2(MIN_LOW + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(MIN_LOW - 1);
    localparam wg_state_e FIRST_ST = (MIN_LOW <= 1) ? ST_ARMED : ST_QUAL;

    wg_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [ADDR_W-1:0] lat_q, lat_d;
    logic              fire;
    logic              legal;
    logic              rise_ok;

    assign legal   = !ctrl.ce_n && ctrl.oe_n && !ctrl.we_n;
    assign rise_ok = ctrl.we_n && !ctrl.ce_n && ctrl.oe_n;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        lat_d   = lat_q;
        fire    = 1'b0;
        if (!supply_ok) begin
            state_d = ST_VOID;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (legal) begin
                        if (ready) begin
                            state_d = FIRST_ST;
                            cnt_d   = CNT_W'(1);
                            lat_d   = s_addr;
                        end else begin
                            state_d = ST_VOID;
                        end
                    end
                end
                ST_QUAL: begin
                    if (!legal) begin
                        state_d = ST_VOID;
                    end else if (cnt_q == LAST_CNT) begin
                        state_d = ST_ARMED;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                ST_ARMED: begin
                    if (legal) begin
                        state_d = ST_ARMED;
                    end else if (rise_ok) begin
                        fire    = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_VOID;
                    end
                end
                ST_VOID: begin
                    if (ctrl.we_n) begin
                        state_d = ST_IDLE;
                    end
                end
                default: state_d = ST_VOID;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_VOID;
            cnt_q   <= '0;
            lat_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            lat_q   <= lat_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_evt  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_evt <= fire;
            if (fire) begin
                wr_addr <= lat_q;
                wr_data <= s_data;
            end
        end
    end

endmodule

// File: rtl/flash_write_guard.sv
module flash_write_guard
    import fwg_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int DATA_W   = 8,
    parameter int MIN_LOW  = 3,
    parameter int BLACKOUT = 1_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              bus_ce_n,
    input  logic              bus_oe_n,
    input  logic              bus_we_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    output logic              wr_evt,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              hold_read
);

    localparam int SYNC_W = 3 + ADDR_W + DATA_W;
    localparam logic [SYNC_W-1:0] SYNC_RST = {3'b111, {(ADDR_W + DATA_W){1'b0}}};

    logic [SYNC_W-1:0] raw_vec;
    logic [SYNC_W-1:0] syn_vec;
    wg_ctrl_t          s_ctrl;
    logic [ADDR_W-1:0] s_addr;
    logic [DATA_W-1:0] s_data;
    logic              ready;

    assign raw_vec = {bus_ce_n, bus_oe_n, bus_we_n, bus_addr, bus_data};
    assign {s_ctrl, s_addr, s_data} = syn_vec;

    wg_sync #(
        .WIDTH   (SYNC_W),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_vec),
        .d_out (syn_vec)
    );

    wg_blackout #(
        .BLACKOUT (BLACKOUT)
    ) u_blackout (
        .clk   (clk),
        .rst_n (rst_n),
        .ready (ready)
    );

    wg_strobe_fsm #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .MIN_LOW (MIN_LOW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .ready     (ready),
        .ctrl      (s_ctrl),
        .s_addr    (s_addr),
        .s_data    (s_data),
        .wr_evt    (wr_evt),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    assign hold_read = !rst_n || !ready || !supply_ok;

endmodule

// File: rtl/flash_write_guard_chk.sv
module flash_write_guard_chk #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              supply_ok,
    input logic              bus_ce_n,
    input logic              bus_oe_n,
    input logic              bus_we_n,
    input logic              wr_evt,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              hold_read
);

    always_comb begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!wr_evt && hold_read); // R1
        end
    end

    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_evt |=> !wr_evt); // R4

    AST_EVT_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_evt |-> !$past(hold_read)); // R2

    AST_EVT_CLEAN_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_evt |-> ($past(bus_we_n, 3) && !$past(bus_ce_n, 3) && $past(bus_oe_n, 3))); // R7

    AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_evt |-> ($stable(wr_addr) && $stable(wr_data))); // R5

    AST_SUPPLY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !wr_evt); // R8

endmodule

bind flash_write_guard flash_write_guard_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .bus_ce_n  (bus_ce_n),
    .bus_oe_n  (bus_oe_n),
    .bus_we_n  (bus_we_n),
    .wr_evt    (wr_evt),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .hold_read (hold_read)
);

// File: tb/test_flash_write_guard.sv
`timescale 1ns/1ps
module test_flash_write_guard;

    localparam int AW  = 18;
    localparam int DW  = 8;
    localparam int MIN = 3;
    localparam int BO  = 40;
    localparam int VW  = 3 + AW + DW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          supply_ok = 1'b1;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data = '0;
    logic          wr_evt, hold_read;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int    total = 0;
    int    bad = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    flash_write_guard #(
        .ADDR_W (AW), .DATA_W (DW), .MIN_LOW (MIN), .BLACKOUT (BO)
    ) i_flash_write_guard (
        .clk (clk), .rst_n (rst_n), .supply_ok (supply_ok),
        .bus_ce_n (ce_n), .bus_oe_n (oe_n), .bus_we_n (we_n),
        .bus_addr (addr), .bus_data (data),
        .wr_evt (wr_evt), .wr_addr (wr_addr), .wr_data (wr_data),
        .hold_read (hold_read)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: sample history, run length, block flag
    logic [VW-1:0] hist[$];
    int            m_edges = 0;
    int            m_run = 0;
    bit            m_block = 1;
    bit            m_live = 0;
    logic          e_evt = 0;
    logic [AW-1:0] e_addr = '0, m_lat = '0;
    logic [DW-1:0] e_data = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = {};
            hist.push_back({3'b111, {(AW + DW){1'b0}}});
            hist.push_back({3'b111, {(AW + DW){1'b0}}});
            m_edges = 0; m_run = 0; m_block = 1; m_live = 0; e_evt = 0;
        end else begin
            logic [VW-1:0] s;
            logic sce, soe, swe, lg, rdy;
            hist.push_back({ce_n, oe_n, we_n, addr, data});
            s = hist.pop_front();
            sce = s[VW-1]; soe = s[VW-2]; swe = s[VW-3];
            rdy = (m_edges >= BO);
            m_edges++;
            m_live = 1;
            lg = !sce && soe && !swe;
            e_evt = 0;
            if (!supply_ok) begin
                m_block = 1; m_run = 0;
            end else if (m_block) begin
                if (swe) m_block = 0;
                m_run = 0;
            end else if (m_run == 0) begin
                if (lg) begin
                    if (rdy) begin m_run = 1; m_lat = s[AW+DW-1:DW]; end
                    else m_block = 1;
                end
            end else if (m_run < MIN) begin
                if (lg) m_run++;
                else begin m_block = 1; m_run = 0; end
            end else if (!lg) begin
                if (swe && !sce && soe) begin
                    e_evt = 1; e_addr = m_lat; e_data = s[DW-1:0];
                end else m_block = 1;
                m_run = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            chk("R1", wr_evt, 0);
            chk("R1", hold_read, 1);
        end else if (m_live) begin
            chk(cur_req, wr_evt, e_evt);
            chk("R2", hold_read, (m_edges < BO) || !supply_ok);
            if (e_evt) begin
                chk("R5", wr_addr, e_addr);
                chk("R5", wr_data, e_data);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ce_n = 1; oe_n = 1; we_n = 1; supply_ok = 1;
        tick(3);
        rst_n = 1'b1;
    endtask

    // strobe led by write-enable; addr changes after start, data set before rise
    task automatic strobe(input logic [AW-1:0] a, input logic [DW-1:0] d, input int low);
        addr = a; data = ~d; ce_n = 0; oe_n = 1;
        tick(1);
        we_n = 0;
        tick(1);
        addr = ~a;
        if (low > 1) tick(low - 1);
        data = d; we_n = 1;
        tick(1);
        ce_n = 1;
        tick(5);
    endtask

    int hits = 0;
    always @(negedge clk) if (rst_n && wr_evt) hits++;

    initial begin
        // R1 and R3: write state held from reset through blackout
        ce_n = 0; we_n = 0; oe_n = 1;
        tick(3);
        rst_n = 1'b1;
        cur_req = "R3";
        tick(BO + 10);
        we_n = 1;
        tick(8);
        ce_n = 1;
        tick(2);
        chk("R3", hits, 0);

        // R3: strobe begun inside the blackout
        do_reset();
        tick(2);
        strobe(18'h01234, 8'h5A, 6);
        chk("R3", hits, 0);
        tick(BO);

        // R4 / R5: normal strobes
        cur_req = "R4";
        strobe(18'h2AAAA, 8'hC3, 5);
        strobe(18'h15555, 8'h3C, 8);
        strobe(18'h3FFFF, 8'hFF, 4);
        chk("R4", hits, 3);

        // R6: width boundary
        cur_req = "R6";
        strobe(18'h00100, 8'h11, MIN - 1);
        strobe(18'h00001, 8'h01, 1);
        chk("R6", hits, 3);
        strobe(18'h00200, 8'h22, MIN);
        chk("R6", hits, 4);

        // R7: output-enable dip, early chip-enable rise, joint rise
        cur_req = "R7";
        addr = 18'h00300; ce_n = 0; tick(1); we_n = 0; tick(4);
        oe_n = 0; tick(1); oe_n = 1; tick(2); we_n = 1; tick(1); ce_n = 1; tick(5);
        addr = 18'h00400; ce_n = 0; tick(1); we_n = 0; tick(5);
        ce_n = 1; tick(2); we_n = 1; tick(5);
        addr = 18'h00500; ce_n = 0; tick(1); we_n = 0; tick(5);
        ce_n = 1; we_n = 1; tick(6);
        chk("R7", hits, 4);

        // R8: supply drop during strobe, while idle, and recovery
        cur_req = "R8";
        addr = 18'h00600; ce_n = 0; tick(1); we_n = 0; tick(5);
        supply_ok = 0; tick(1); supply_ok = 1; tick(3);
        we_n = 1; tick(1); ce_n = 1; tick(5);
        supply_ok = 0; tick(4); supply_ok = 1; tick(2);
        chk("R8", hits, 4);
        strobe(18'h00777, 8'h77, 5);
        chk("R8", hits, 5);

        // R9: chip-enable led strobe
        cur_req = "R9";
        addr = 18'h0ABCD; data = 8'h00; we_n = 0; oe_n = 1;
        tick(2);
        ce_n = 0; tick(1); addr = 18'h0DCBA; tick(4);
        data = 8'h9E; we_n = 1; tick(1); ce_n = 1; tick(6);
        chk("R9", hits, 6);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule